// File: doc/BRIEF.md
# Circular Interrupt Event Queue Writer

This block takes channel interrupt events from up to `NQ` requester lanes and posts each one as a 32-bit entry into a circular queue kept in a shared word RAM. Every queue is described by a 16-byte parameter record in the same RAM. The record holds the queue base, the current entry pointer, a running down-counter and its reload value. For each accepted event the block reads the record, then reads the target entry. If the entry is free, the block writes the new entry, moves the pointer and updates the counter. If the entry is still occupied, the block raises an overflow pulse and leaves the RAM untouched.

The host owns the layout of the ring. It sets a wrap flag in the last entry, and it frees entries by clearing their valid bit through its own RAM port. The writer never needs the ring length. A one-cycle global interrupt pulse per queue reports each time a programmable number of events has been posted, so the host can take one interrupt for a group of entries.

The RAM port has a single-cycle read latency and big-endian halfword placement. The first halfword of a word sits in bits 31:16.

Top module: `irq_queue_writer`

## Requirements
- R1: When several lanes request at once, the lowest-index lane is accepted first. `ack_o` is at most one-hot, is combinational on `req_i`, and is asserted only while the block is idle.
- R2: An `ack_o` bit accepts that lane's event. `busy_o` is high from the next cycle until the RAM sequence completes, and no further lane is accepted during that time.
- R3: A posted entry word has bit 31 (valid) = 1. Bits 20:16 hold the event mask, with input bit 0 = receive buffer done, 1 = transmit buffer done, 2 = busy/cells discarded, 3 = receive frame complete and 4 = transmit buffer not ready. Bits 15:0 hold the channel code. Bits 30 and 28:21 are written as zero.
- R4: The wrap flag (bit 29) read from the target entry is written back unchanged. After writing an entry whose wrap flag is set, the pointer becomes the queue base.
- R5: After writing an entry without the wrap flag, the pointer advances by 4 bytes. The new pointer is written to record offset 4.
- R6: Each posted entry decrements the counter in bits 31:16 of the word at record offset 8.
- R7: If the counter held 1 or 0 before the decrement, the counter is reloaded from the initial count in bits 15:0 of that word. That queue's `gint_o` bit then pulses for one cycle.
- R8: If the target entry's valid bit is already set, no entry is written, the pointer and counter are left unchanged, and that queue's `ovf_o` bit pulses for one cycle.
- R9: The record of queue q is at byte address `TBL_BASE + 16*q`. Its word at +0 is the queue base, +4 the current pointer, and +8 the counter and initial count.
- R10: The counter write uses byte enables 4'b1100, so the initial-count halfword is never altered. A read and a write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NQ | Per-lane event request, held until acknowledged |
| evt_i | input | NQ*5 | Per-lane event mask, lane q in bits 5q+4:5q |
| chan_i | input | NQ*16 | Per-lane channel code, lane q in bits 16q+15:16q |
| ack_o | output | NQ | One-hot acceptance of a lane's request |
| busy_o | output | 1 | A read-modify-write sequence is in progress |
| mem_addr_o | output | AW | RAM byte address, word aligned |
| mem_rd_o | output | 1 | RAM read strobe, data returned next cycle |
| mem_wr_o | output | 1 | RAM write strobe |
| mem_be_o | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata_o | output | 32 | RAM write data |
| mem_rdata_i | input | 32 | RAM read data |
| gint_o | output | NQ | Per-queue global interrupt pulse |
| ovf_o | output | NQ | Per-queue queue-full pulse |

## Verification
The bench fills rings of two to five entries until they overflow, has the host free the entries, and then drives each ring around its wrap point again. A writer that ignored the wrap flag would run past the ring. A writer that dropped the flag would lose the ring boundary for the next lap. Queues with reload values 1 to 4 check that the global pulse comes on exactly every N-th post. An off-by-one in the counter, or a write that disturbed the reload halfword, would shift every later pulse. During overflow the bench checks that neither the pointer nor the counter moved, and a three-lane simultaneous request checks the service order.

// File: rtl/iqw_pkg.sv
package iqw_pkg;
   localparam int EVT_W     = 5;
   localparam int CC_W      = 16;
   localparam int DW        = 32;
   localparam int REC_BYTES = 16;
   localparam int ENT_BYTES = 4;
   localparam int V_POS     = 31;
   localparam int W_POS     = 29;
   localparam int EVT_LSB   = 16;
   localparam int OFS_PTR   = 4;
   localparam int OFS_CNT   = 8;

   typedef enum logic [3:0] {
      S_IDLE, S_RBASE, S_RPTR, S_RCNT, S_RENT,
      S_CHK, S_DEC, S_WENT, S_WPTR, S_WCNT
   } seq_state_e;

   function automatic logic [DW-1:0] iqw_pack(input logic wrap,
                                              input logic [EVT_W-1:0] evt,
                                              input logic [CC_W-1:0] cc);
      logic [DW-1:0] w;
      w = '0;
      w[V_POS] = 1'b1;
      w[W_POS] = wrap;
      w[EVT_LSB +: EVT_W] = evt;
      w[CC_W-1:0] = cc;
      return w;
   endfunction
endpackage

// File: rtl/iqw_arb.sv
module iqw_arb #(
   parameter int NQ = 4,
   parameter int QW = 2
) (
   input  logic [NQ-1:0] req_i,
   output logic [NQ-1:0] gnt_o,
   output logic [QW-1:0] idx_o
);
   logic [NQ:0] taken;
   assign taken[0] = 1'b0;

   for (genvar i = 0; i < NQ; i++) begin : g_lane
      assign gnt_o[i]     = req_i[i] & ~taken[i];
      assign taken[i + 1] = taken[i] | req_i[i];
   end

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < NQ; i++)
         if (gnt_o[i]) idx_o = QW'(i);
   end
endmodule

// File: rtl/iqw_calc.sv
module iqw_calc #(
   parameter int AW    = 16,
   parameter int CNT_W = 16
) (
   input  logic              ent_valid_i,
   input  logic              ent_wrap_i,
   input  logic [AW-1:0]     base_i,
   input  logic [AW-1:0]     ptr_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [CNT_W-1:0]  icnt_i,
   input  logic [iqw_pkg::EVT_W-1:0] evt_i,
   input  logic [iqw_pkg::CC_W-1:0]  chan_i,
   output logic              full_o,
   output logic              fire_o,
   output logic [AW-1:0]     nxt_ptr_o,
   output logic [CNT_W-1:0]  nxt_cnt_o,
   output logic [iqw_pkg::DW-1:0] ent_wr_o
);
   import iqw_pkg::*;

   assign full_o    = ent_valid_i;
   assign nxt_ptr_o = ent_wrap_i ? base_i : ptr_i + AW'(ENT_BYTES);
   assign fire_o    = (cnt_i <= CNT_W'(1));
   assign nxt_cnt_o = fire_o ? icnt_i : cnt_i - CNT_W'(1);
   assign ent_wr_o  = iqw_pack(ent_wrap_i, evt_i, chan_i);
endmodule

// File: rtl/iqw_seq.sv
module iqw_seq #(
   parameter int NQ       = 4,
   parameter int QW       = 2,
   parameter int AW       = 16,
   parameter int TBL_BASE = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [QW-1:0]           q_i,
   input  logic [iqw_pkg::EVT_W-1:0] evt_i,
   input  logic [iqw_pkg::CC_W-1:0]  chan_i,
   output logic                    busy_o,
   output logic [AW-1:0]           mem_addr_o,
   output logic                    mem_rd_o,
   output logic                    mem_wr_o,
   output logic [3:0]              mem_be_o,
   output logic [iqw_pkg::DW-1:0]  mem_wdata_o,
   input  logic [iqw_pkg::DW-1:0]  mem_rdata_i,
   output logic                    ent_valid_o,
   output logic                    ent_wrap_o,
   output logic [AW-1:0]           base_o,
   output logic [AW-1:0]           ptr_o,
   output logic [15:0]             cnt_o,
   output logic [15:0]             icnt_o,
   output logic [iqw_pkg::EVT_W-1:0] evt_o,
   output logic [iqw_pkg::CC_W-1:0]  chan_o,
   input  logic                    full_i,
   input  logic                    fire_i,
   input  logic [AW-1:0]           nxt_ptr_i,
   input  logic [15:0]             nxt_cnt_i,
   input  logic [iqw_pkg::DW-1:0]  ent_wr_i,
   output logic [NQ-1:0]           gint_o,
   output logic [NQ-1:0]           ovf_o
);
   import iqw_pkg::*;

   seq_state_e    st;
   logic [QW-1:0] q_r;
   logic [AW-1:0] rec;
   logic [NQ-1:0] q_hot;

   assign rec    = AW'(TBL_BASE) + (AW'(q_r) << 4);
   assign q_hot  = NQ'(1) << q_r;
   assign busy_o = (st != S_IDLE);

   always_comb begin
      mem_addr_o  = rec;
      mem_rd_o    = 1'b0;
      mem_wr_o    = 1'b0;
      mem_be_o    = 4'b1111;
      mem_wdata_o = '0;
      case (st)
         S_RBASE: mem_rd_o = 1'b1;
         S_RPTR:  begin mem_rd_o = 1'b1; mem_addr_o = rec + AW'(OFS_PTR); end
         S_RCNT:  begin mem_rd_o = 1'b1; mem_addr_o = rec + AW'(OFS_CNT); end
         S_RENT:  begin mem_rd_o = 1'b1; mem_addr_o = ptr_o; end
         S_WENT:  begin
            mem_wr_o    = 1'b1;
            mem_addr_o  = ptr_o;
            mem_wdata_o = ent_wr_i;
         end
         S_WPTR:  begin
            mem_wr_o    = 1'b1;
            mem_addr_o  = rec + AW'(OFS_PTR);
            mem_wdata_o = DW'(nxt_ptr_i);
         end
         S_WCNT:  begin
            mem_wr_o    = 1'b1;
            mem_addr_o  = rec + AW'(OFS_CNT);
            mem_be_o    = 4'b1100;
            mem_wdata_o = {nxt_cnt_i, 16'h0000};
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         q_r         <= '0;
         evt_o       <= '0;
         chan_o      <= '0;
         base_o      <= '0;
         ptr_o       <= '0;
         cnt_o       <= '0;
         icnt_o      <= '0;
         ent_valid_o <= 1'b0;
         ent_wrap_o  <= 1'b0;
         gint_o      <= '0;
         ovf_o       <= '0;
      end else begin
         gint_o <= '0;
         ovf_o  <= '0;
         case (st)
            S_IDLE: if (start_i) begin
               q_r    <= q_i;
               evt_o  <= evt_i;
               chan_o <= chan_i;
               st     <= S_RBASE;
            end
            S_RBASE: st <= S_RPTR;
            S_RPTR: begin
               base_o <= mem_rdata_i[AW-1:0];
               st     <= S_RCNT;
            end
            S_RCNT: begin
               ptr_o <= mem_rdata_i[AW-1:0];
               st    <= S_RENT;
            end
            S_RENT: begin
               cnt_o  <= mem_rdata_i[31:16];
               icnt_o <= mem_rdata_i[15:0];
               st     <= S_CHK;
            end
            S_CHK: begin
               ent_valid_o <= mem_rdata_i[V_POS];
               ent_wrap_o  <= mem_rdata_i[W_POS];
               st          <= S_DEC;
            end
            S_DEC: begin
               if (full_i) begin
                  ovf_o <= q_hot;
                  st    <= S_IDLE;
               end else begin
                  st <= S_WENT;
               end
            end
            S_WENT: st <= S_WPTR;
            S_WPTR: st <= S_WCNT;
            S_WCNT: begin
               gint_o <= fire_i ? q_hot : '0;
               st     <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/irq_queue_writer.sv
module irq_queue_writer #(
   parameter int NQ       = 4,
   parameter int AW       = 16,
   parameter int TBL_BASE = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NQ-1:0]           req_i,
   input  logic [NQ*5-1:0]         evt_i,
   input  logic [NQ*16-1:0]        chan_i,
   output logic [NQ-1:0]           ack_o,
   output logic                    busy_o,
   output logic [AW-1:0]           mem_addr_o,
   output logic                    mem_rd_o,
   output logic                    mem_wr_o,
   output logic [3:0]              mem_be_o,
   output logic [31:0]             mem_wdata_o,
   input  logic [31:0]             mem_rdata_i,
   output logic [NQ-1:0]           gint_o,
   output logic [NQ-1:0]           ovf_o
);
   import iqw_pkg::*;

   localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;

   if (NQ < 1 || NQ > 16) begin : g_bad_nq
      $error("irq_queue_writer: NQ must be 1..16");
   end
   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("irq_queue_writer: AW must be 8..32");
   end
   if ((TBL_BASE % REC_BYTES) != 0) begin : g_bad_tbl
      $error("irq_queue_writer: TBL_BASE must be 16-byte aligned");
   end

   logic [NQ-1:0]    gnt;
   logic [QW-1:0]    sel;
   logic             ent_valid, ent_wrap, full, fire;
   logic [AW-1:0]    base, ptr, nxt_ptr;
   logic [15:0]      cnt, icnt, nxt_cnt;
   logic [EVT_W-1:0] evt_r;
   logic [CC_W-1:0]  chan_r;
   logic [DW-1:0]    ent_wr;

   iqw_arb #(.NQ(NQ), .QW(QW)) u_arb (
      .req_i (req_i),
      .gnt_o (gnt),
      .idx_o (sel)
   );

   assign ack_o = busy_o ? '0 : gnt;

   iqw_seq #(.NQ(NQ), .QW(QW), .AW(AW), .TBL_BASE(TBL_BASE)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (|req_i),
      .q_i         (sel),
      .evt_i       (evt_i[sel*EVT_W +: EVT_W]),
      .chan_i      (chan_i[sel*CC_W +: CC_W]),
      .busy_o      (busy_o),
      .mem_addr_o  (mem_addr_o),
      .mem_rd_o    (mem_rd_o),
      .mem_wr_o    (mem_wr_o),
      .mem_be_o    (mem_be_o),
      .mem_wdata_o (mem_wdata_o),
      .mem_rdata_i (mem_rdata_i),
      .ent_valid_o (ent_valid),
      .ent_wrap_o  (ent_wrap),
      .base_o      (base),
      .ptr_o       (ptr),
      .cnt_o       (cnt),
      .icnt_o      (icnt),
      .evt_o       (evt_r),
      .chan_o      (chan_r),
      .full_i      (full),
      .fire_i      (fire),
      .nxt_ptr_i   (nxt_ptr),
      .nxt_cnt_i   (nxt_cnt),
      .ent_wr_i    (ent_wr),
      .gint_o      (gint_o),
      .ovf_o       (ovf_o)
   );

   iqw_calc #(.AW(AW), .CNT_W(16)) u_calc (
      .ent_valid_i (ent_valid),
      .ent_wrap_i  (ent_wrap),
      .base_i      (base),
      .ptr_i       (ptr),
      .cnt_i       (cnt),
      .icnt_i      (icnt),
      .evt_i       (evt_r),
      .chan_i      (chan_r),
      .full_o      (full),
      .fire_o      (fire),
      .nxt_ptr_o   (nxt_ptr),
      .nxt_cnt_o   (nxt_cnt),
      .ent_wr_o    (ent_wr)
   );
endmodule

// File: rtl/iqw_chk.sv
module iqw_chk #(
   parameter int NQ = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [NQ-1:0] req_i,
   input logic [NQ-1:0] ack_o,
   input logic          busy_o,
   input logic          mem_rd_o,
   input logic          mem_wr_o,
   input logic [3:0]    mem_be_o,
   input logic [NQ-1:0] gint_o,
   input logic [NQ-1:0] ovf_o
);
   // R1
   ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_o));
   // R1
   ack_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ack_o) |-> ((NQ'(ack_o - NQ'(1)) & req_i) == '0));
   // R2
   ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ack_o) |-> !busy_o);
   // R2
   ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ack_o) |=> busy_o);
   // R10
   rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_o && mem_wr_o));
   // R10
   be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_o |-> (mem_be_o == 4'b1111 || mem_be_o == 4'b1100));
   // R7
   gint_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gint_o));
   // R8
   ovf_gint_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((|ovf_o) && (|gint_o)));
   // R2
   wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_o || mem_rd_o) |-> busy_o);
endmodule

bind irq_queue_writer iqw_chk #(.NQ(NQ)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_i    (req_i),
   .ack_o    (ack_o),
   .busy_o   (busy_o),
   .mem_rd_o (mem_rd_o),
   .mem_wr_o (mem_wr_o),
   .mem_be_o (mem_be_o),
   .gint_o   (gint_o),
   .ovf_o    (ovf_o)
);

// File: tb/sim_irq_queue_writer.sv
module sim_irq_queue_writer;
   localparam int NQ  = 4;
   localparam int AW  = 12;
   localparam int TBL = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [NQ-1:0]    req = '0;
   logic [NQ*5-1:0]  evt_bus = '0;
   logic [NQ*16-1:0] chan_bus = '0;
   logic [NQ-1:0]    ack_o, gint_o, ovf_o;
   logic             busy_o, mem_rd, mem_wr;
   logic [AW-1:0]    mem_addr;
   logic [3:0]       mem_be;
   logic [31:0]      mem_wdata, mem_rdata;

   irq_queue_writer #(.NQ(NQ), .AW(AW), .TBL_BASE(TBL)) u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req), .evt_i(evt_bus), .chan_i(chan_bus),
      .ack_o(ack_o), .busy_o(busy_o), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
      .mem_wr_o(mem_wr), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
      .mem_rdata_i(mem_rdata), .gint_o(gint_o), .ovf_o(ovf_o)
   );

   // shared RAM: block port plus host port
   logic [31:0] ram [0:1023];
   logic        h_we = 1'b0;
   logic [9:0]  h_addr = '0;
   logic [31:0] h_data = '0;
   always @(posedge clk) begin
      if (mem_wr)
         for (int b = 0; b < 4; b++)
            if (mem_be[b]) ram[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      if (h_we) ram[h_addr] <= h_data;
      if (mem_rd) mem_rdata <= ram[mem_addr[11:2]];
   end

   int gint_seen [NQ];
   int ovf_seen  [NQ];
   initial for (int i = 0; i < NQ; i++) begin gint_seen[i] = 0; ovf_seen[i] = 0; end
   always @(posedge clk)
      for (int i = 0; i < NQ; i++) begin
         if (gint_o[i]) gint_seen[i]++;
         if (ovf_o[i])  ovf_seen[i]++;
      end

   int checks = 0, errors = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // bench model
   int qbase [NQ], nent [NQ], icnt [NQ], ecnt [NQ], eidx [NQ], gexp [NQ], oexp [NQ];
   bit          ev [NQ][8];
   logic [31:0] ew [NQ][8];

   function automatic int rec_w(input int q, input int ofs);
      return (TBL + 16*q + ofs) >> 2;
   endfunction

   task automatic hwrite(input int widx, input logic [31:0] d);
      @(negedge clk);
      h_we = 1'b1; h_addr = widx[9:0]; h_data = d;
      @(negedge clk);
      h_we = 1'b0;
   endtask

   task automatic model_check(input int q, input logic [4:0] e, input logic [15:0] c);
      int w;
      logic [31:0] expw, ptr_exp, cnt_exp;
      bit wrap;
      w = eidx[q];
      if (ev[q][w]) begin
         oexp[q]++;
         chk(ovf_seen[q] == oexp[q], "R8 overflow pulse", ovf_seen[q], oexp[q]);
         chk(ram[(qbase[q] + 4*w) >> 2] == ew[q][w], "R8 entry untouched",
             ram[(qbase[q] + 4*w) >> 2], ew[q][w]);
      end else begin
         wrap = (w == nent[q] - 1);
         expw = {1'b1, 1'b0, wrap, 8'h00, e, c};
         ew[q][w] = expw;
         ev[q][w] = 1'b1;
         eidx[q]  = wrap ? 0 : w + 1;
         if (ecnt[q] <= 1) begin ecnt[q] = icnt[q]; gexp[q]++; end
         else ecnt[q]--;
         chk(ram[(qbase[q] + 4*w) >> 2] == expw, "R3 R4 entry word",
             ram[(qbase[q] + 4*w) >> 2], expw);
      end
      ptr_exp = qbase[q] + 4*eidx[q];
      cnt_exp = {ecnt[q][15:0], icnt[q][15:0]};
      chk(ram[rec_w(q, 4)] == ptr_exp, "R5 R4 R9 pointer", ram[rec_w(q, 4)], ptr_exp);
      chk(ram[rec_w(q, 8)] == cnt_exp, "R6 R10 counter word", ram[rec_w(q, 8)], cnt_exp);
      chk(gint_seen[q] == gexp[q], "R7 global pulse count", gint_seen[q], gexp[q]);
      chk(ovf_seen[q] == oexp[q], "R8 overflow count", ovf_seen[q], oexp[q]);
   endtask

   task automatic post(input int q, input logic [4:0] e, input logic [15:0] c);
      @(negedge clk);
      req[q] = 1'b1;
      evt_bus[q*5 +: 5] = e;
      chan_bus[q*16 +: 16] = c;
      #1;
      while (!ack_o[q]) begin @(negedge clk); #1; end
      @(negedge clk);
      req[q] = 1'b0;
      chk(busy_o == 1'b1, "R2 busy after accept", busy_o, 1);
      chk(ack_o == '0, "R2 no ack while busy", ack_o, 0);
      while (busy_o) @(negedge clk);
      @(negedge clk);
      model_check(q, e, c);
   endtask

   task automatic free_all;
      for (int q = 0; q < NQ; q++)
         for (int k = 0; k < nent[q]; k++)
            if (ev[q][k]) begin
               ew[q][k][31] = 1'b0;
               ev[q][k] = 1'b0;
               hwrite((qbase[q] + 4*k) >> 2, ew[q][k]);
            end
   endtask

   task automatic report;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
         report();
      end
   end

   initial begin
      int ord [3];
      for (int i = 0; i < 1024; i++) ram[i] = '0;
      repeat (3) @(negedge clk);
      // reset state
      chk(busy_o == 1'b0, "R2 reset busy", busy_o, 0);
      chk(mem_wr == 1'b0 && mem_rd == 1'b0, "R10 reset memory idle", {mem_rd, mem_wr}, 0);
      chk(gint_o == '0 && ovf_o == '0, "R7 R8 reset pulses", {gint_o, ovf_o}, 0);
      rst_n = 1'b1;

      for (int q = 0; q < NQ; q++) begin
         qbase[q] = 'h100 + 'h40*q;
         nent[q]  = q + 2;
         icnt[q]  = q + 1;
         ecnt[q]  = icnt[q];
         eidx[q]  = 0;
         gexp[q]  = 0;
         oexp[q]  = 0;
         hwrite(rec_w(q, 0), qbase[q]);
         hwrite(rec_w(q, 4), qbase[q]);
         hwrite(rec_w(q, 8), {ecnt[q][15:0], icnt[q][15:0]});
         for (int k = 0; k < 8; k++) begin
            ev[q][k] = 1'b0;
            ew[q][k] = (k == nent[q] - 1) ? 32'h2040_5A5A : 32'h0040_5A5A;
            if (k < nent[q]) hwrite((qbase[q] + 4*k) >> 2, ew[q][k]);
         end
      end

      // fill every ring and run into overflow (R8)
      for (int q = 0; q < NQ; q++)
         for (int k = 0; k < nent[q] + 2; k++)
            post(q, 5'(((k*3 + q) % 31) + 1), 16'(q*256 + k));

      // host frees entries; second lap crosses the wrap point (R4)
      free_all();
      for (int q = 0; q < NQ; q++)
         for (int k = 0; k < nent[q] + 1; k++)
            post(q, 5'(1 << (k % 5)), 16'(16'hA000 + q*16 + k));

      // simultaneous requests on lanes 1..3 (R1)
      free_all();
      @(negedge clk);
      for (int q = 1; q < 4; q++) begin
         req[q] = 1'b1;
         evt_bus[q*5 +: 5] = 5'(q + 8);
         chan_bus[q*16 +: 16] = 16'(16'hC000 + q);
      end
      for (int n = 0; n < 3; n++) begin
         int g;
         #1;
         while (ack_o == '0) begin @(negedge clk); #1; end
         g = 0;
         for (int i = 0; i < NQ; i++) if (ack_o[i]) g = i;
         ord[n] = g;
         @(negedge clk);
         req[g] = 1'b0;
         while (busy_o) @(negedge clk);
      end
      @(negedge clk);
      for (int n = 0; n < 3; n++)
         chk(ord[n] == n + 1, "R1 fixed priority order", ord[n], n + 1);
      for (int q = 1; q < 4; q++)
         model_check(q, 5'(q + 8), 16'(16'hC000 + q));

      finished = 1;
      report();
   end
endmodule